// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block bridges a clocked request port to a 16-bit asynchronous static RAM. A requester presents a read or a write with an address, write data and a two-bit byte mask. The controller latches it and plays out the chip-select, write-enable, output-enable and byte-enable strobes with phases whose lengths are whole numbers of clock cycles. It signals completion with a one-cycle done pulse, and for reads it returns the captured data at the same time.

Every analog limit is a parameter in nanoseconds next to the clock period parameter. The controller converts each limit to a cycle count, rounding up, with a minimum of one cycle. Addresses change only while write enable is high. The data bus is driven only after the memory's output drivers have had time to turn off following a read.

Top module: `asram_bridge`

## Requirements
- R1: During and directly after reset, reqReady is 1, reqDone is 0, memCsN, memWeN, memOeN, memUbN and memLbN are all 1, and memDoe is 0.
- R2: A cycle count is ceil(limit_ns / CLK_NS), but never less than 1. A read holds memCsN and memOeN low for RD = cycles(55 ns) cycles with the address steady, samples memDin at the end of the last such cycle, and presents the word on reqRdata in the cycle where reqDone is 1.
- R3: reqMask bit 0 selects the lower lane (data bits 7:0, memLbN) and bit 1 selects the upper lane (bits 15:8, memUbN). A write leaves a deselected lane of memory unchanged. A read returns 0 in a deselected lane of reqRdata.
- R4: A write runs in three phases. First comes one setup cycle with memCsN and the selected byte enables low, memWeN high and memDoe 1. Next, memWeN is low for WP = cycles(40 ns) cycles, which covers the pulse-width, data-setup, select-to-end and address-to-end limits. Last come H = max(1, cycles(55 ns) - 1 - WP) cycles with memWeN high and the data still driven.
- R5: memAddr and memDout do not change while memWeN is low. A write pulse is at least 35 ns long, and memCsN goes low at least 40 ns before memWeN rises.
- R6: memDoe is never 1 while memOeN is 0. After memOeN rises, memDoe stays 0 for at least TZ = cycles(20 ns) cycles.
- R7: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady is 0 in the next cycle. It becomes 1 again RD + TZ cycles after the accepting edge for a read, and WP + H + 2 cycles after it for a write.
- R8: A request whose mask is 00 produces no strobe. reqDone is 1 in the cycle right after acceptance, reqReady is 0 in that same cycle only, and memory is left unchanged.
- R9: reqDone is a single-cycle pulse. It is issued exactly once per accepted request: RD cycles after acceptance for a read and WP + H + 1 cycles after it for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte lane select, bit 0 lower, bit 1 upper |
| reqReady | output | 1 | Controller can take a request |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 16 | Read data, valid with reqDone |
| memAddr | output | ADDR_W | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |
| memDout | output | 16 | Data toward memory |
| memDoe | output | 1 | Data bus drive enable |
| memDin | input | 16 | Data from memory |

## Verification
The bench's memory model delays its read data by the full access time and puts filler bytes in lanes that are not enabled. If the controller captures too early, or passes disabled lanes through, the read word is wrong. Timing monitors measure the write pulse width, the data setup time, the select-to-end time and the gap between output enable rising and the bus being driven. A shortened phase or a missing turnaround after a read shows up as a measured violation. Directed cases cover a write straight after a read, single-lane writes and reads, and null-mask requests, which must neither strobe the chip nor hold the port busy. A random mix of operations on a small address range confirms read-after-write data against a shadow copy.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_TURN,
    S_WSETUP,
    S_WPULSE,
    S_WHOLD
  } ctrlState_t;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic csOn;
    logic weOn;
    logic oeOn;
    logic beOn;
    logic driveOn;
    logic load;
    logic capture;
  } strobe_t;

  // Whole clock cycles covering a limit in ns, at least one.
  function automatic int cyclesFor(int limitNs, int periodNs);
    int c;
    c = (limitNs + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int WP_CYC   = 4,
  parameter int HOLD_CYC = 1,
  parameter int TZ_CYC   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic    reqReady,
  output logic    reqDone,
  output strobe_t stb
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(HOLD_CYC, TZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic doneQ, nextDone;
  logic [CNT_W-1:0] pulseCnt;

  assign reqReady = (state == S_IDLE) && !doneQ;
  assign reqDone  = doneQ;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextDone  = 1'b0;
    stb       = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid && reqReady) begin
          stb.load = 1'b1;
          if (reqMask == '0) begin
            nextDone = 1'b1;
          end else if (reqWrite) begin
            nextState = S_WSETUP;
          end else begin
            nextState = S_READ;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      S_READ: begin
        stb.csOn = 1'b1;
        stb.oeOn = 1'b1;
        stb.beOn = 1'b1;
        if (cnt == '0) begin
          stb.capture = 1'b1;
          nextDone    = 1'b1;
          nextState   = S_TURN;
          nextCnt     = CNT_W'(TZ_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_TURN: begin
        if (cnt == '0) nextState = S_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      S_WSETUP: begin
        stb.csOn    = 1'b1;
        stb.beOn    = 1'b1;
        stb.driveOn = 1'b1;
        nextState   = S_WPULSE;
        nextCnt     = CNT_W'(WP_CYC - 1);
      end
      S_WPULSE: begin
        stb.csOn    = 1'b1;
        stb.beOn    = 1'b1;
        stb.driveOn = 1'b1;
        stb.weOn    = 1'b1;
        if (cnt == '0) begin
          nextState = S_WHOLD;
          nextCnt   = CNT_W'(HOLD_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_WHOLD: begin
        stb.csOn    = 1'b1;
        stb.beOn    = 1'b1;
        stb.driveOn = 1'b1;
        if (cnt == '0) begin
          nextState = S_IDLE;
          nextDone  = 1'b1;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      doneQ <= nextDone;
    end
  end

  // Independent count of write-pulse cycles, used only for checking.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseCnt <= '0;
    else if (state == S_WPULSE) pulseCnt <= pulseCnt + 1'b1;
    else                        pulseCnt <= '0;
  end

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WPULSE && cnt == '0) |-> pulseCnt == CNT_W'(WP_CYC - 1));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_null_no_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMask == '0) |=> (state == S_IDLE));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int TZ_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic [DATA_W-1:0] reqRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin
);

  localparam int GAP_W = $clog2(TZ_CYC + 1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic [LANES-1:0]  laneEnN;
  logic [GAP_W-1:0]  offGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (stb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneEnN[i] = !(stb.beOn && maskQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqRdata[i*LANE_W +: LANE_W] <= '0;
      end else if (stb.capture) begin
        reqRdata[i*LANE_W +: LANE_W] <= maskQ[i] ? memDin[i*LANE_W +: LANE_W] : '0;
      end
    end
  end

  assign memAddr = addrQ;
  assign memDout = wdataQ;
  assign memCsN  = !stb.csOn;
  assign memWeN  = !stb.weOn;
  assign memOeN  = !stb.oeOn;
  assign memDoe  = stb.driveOn;
  assign memLbN  = laneEnN[0];
  assign memUbN  = laneEnN[1];

  // Cycles since the memory outputs were last enabled, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      offGap <= GAP_W'(TZ_CYC);
    else if (!memOeN)               offGap <= '0;
    else if (offGap < GAP_W'(TZ_CYC)) offGap <= offGap + 1'b1;
  end

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memDoe && !memOeN));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> offGap >= GAP_W'(TZ_CYC));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |=> ($stable(memAddr) && $stable(memDout)));

  assert_we_needs_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memDoe));

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/1ps
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_NS    = 10,
  parameter int RC_NS     = 55,
  parameter int WC_NS     = 55,
  parameter int WP_NS     = 35,
  parameter int DW_NS     = 25,
  parameter int CW_NS     = 40,
  parameter int AW_NS     = 40,
  parameter int BW_NS     = 35,
  parameter int OHZ_NS    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqMask,
  output logic              reqReady,
  output logic              reqDone,
  output logic [15:0]       reqRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [15:0]       memDout,
  output logic              memDoe,
  input  logic [15:0]       memDin
);

  localparam int RD_CYC   = cyclesFor(RC_NS, CLK_NS);
  localparam int WLOW_NS  = maxOf(maxOf(WP_NS, DW_NS), maxOf(maxOf(CW_NS, AW_NS), BW_NS));
  localparam int WP_CYC   = cyclesFor(WLOW_NS, CLK_NS);
  localparam int WC_CYC   = cyclesFor(WC_NS, CLK_NS);
  localparam int HOLD_CYC = maxOf(1, WC_CYC - 1 - WP_CYC);
  localparam int TZ_CYC   = cyclesFor(OHZ_NS, CLK_NS);

  strobe_t stb;

  asram_ctrl #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .HOLD_CYC(HOLD_CYC),
    .TZ_CYC  (TZ_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .reqDone (reqDone),
    .stb     (stb)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .TZ_CYC(TZ_CYC)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .reqRdata(reqRdata),
    .memAddr (memAddr),
    .memCsN  (memCsN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memUbN  (memUbN),
    .memLbN  (memLbN),
    .memDout (memDout),
    .memDoe  (memDoe),
    .memDin  (memDin)
  );

endmodule

// File: tb/test_asram_bridge.sv
`timescale 1ns/1ps
module test_asram_bridge;

  localparam int CLK_NS  = 10;
  localparam int ADDR_W  = 8;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ACC_NS  = 55;

  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD = (55 + CLK_NS - 1) / CLK_NS;
  localparam int WP = (40 + CLK_NS - 1) / CLK_NS;
  localparam int WC = (55 + CLK_NS - 1) / CLK_NS;
  localparam int H  = (WC - 1 - WP) < 1 ? 1 : (WC - 1 - WP);
  localparam int TZ = (20 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic reqReady, reqDone;
  logic [15:0] reqRdata;
  logic [ADDR_W-1:0] memAddr;
  logic memCsN, memWeN, memOeN, memUbN, memLbN, memDoe;
  logic [15:0] memDout, memDin;

  int checks = 0;
  int errors = 0;
  int csFalls = 0;
  bit finished = 0;

  logic [15:0] mem    [DEPTH];
  logic [15:0] shadow [DEPTH];
  logic [15:0] readWord;
  realtime weFallT = 0, csFallT = 0, doutT = 0, oeRiseT = -1000;

  always #(CLK_NS/2) clk = ~clk;

  asram_bridge #(.ADDR_W(ADDR_W), .CLK_NS(CLK_NS)) i_asram_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .reqDone(reqDone), .reqRdata(reqRdata),
    .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memUbN(memUbN), .memLbN(memLbN), .memDout(memDout), .memDoe(memDoe),
    .memDin(memDin)
  );

  // Memory model: enabled lanes read memory, others carry filler bytes;
  // the word only settles a full access time after its last change.
  always_comb begin
    if (!memCsN && !memOeN && memWeN) begin
      readWord[7:0]  = !memLbN ? mem[memAddr][7:0]  : 8'hC3;
      readWord[15:8] = !memUbN ? mem[memAddr][15:8] : 8'h3C;
    end else begin
      readWord = 16'hE1E1;
    end
  end
  assign #(ACC_NS) memDin = readWord;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge memCsN) begin
    csFallT = $realtime;
    if (rstN) csFalls++;
  end
  always @(negedge memWeN) weFallT = $realtime;
  always @(memDout) doutT = $realtime;
  always @(posedge memOeN) oeRiseT = $realtime;

  always @(memAddr) begin
    if (rstN && !memWeN && !memCsN)
      check(1'b0, "R5", "address moved during write pulse", 1, 0);
  end

  always @(posedge memWeN) begin
    if (rstN && !memCsN) begin
      check(($realtime - weFallT) >= 35.0, "R5", "write pulse ns", int'($realtime - weFallT), 35);
      check(($realtime - doutT) >= 25.0, "R5", "data setup ns", int'($realtime - doutT), 25);
      check(($realtime - csFallT) >= 40.0, "R5", "select to write end ns", int'($realtime - csFallT), 40);
      check(memDoe == 1'b1, "R4", "bus driven at write end", int'(memDoe), 1);
      if (!memLbN) mem[memAddr][7:0]  = memDout[7:0];
      if (!memUbN) mem[memAddr][15:8] = memDout[15:8];
    end
  end

  always @(posedge memDoe) begin
    if (rstN)
      check(($realtime - oeRiseT) >= 20.0, "R6", "turnaround ns", int'($realtime - oeRiseT), 20);
  end

  always @(negedge clk) begin
    if (rstN && memDoe && !memOeN)
      check(1'b0, "R6", "drive while outputs on", 1, 0);
  end

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] m);
    logic [15:0] r;
    r = old;
    if (m[0]) r[7:0]  = d[7:0];
    if (m[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  function automatic logic [15:0] laneView(logic [15:0] w, logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic doOp(bit wr, logic [ADDR_W-1:0] a, logic [15:0] d, logic [1:0] m);
    int n;
    int r;
    int expDone;
    int expReady;
    int fallsBefore;
    if (m == 2'b00) begin
      expDone = 0; expReady = 1;
    end else if (wr) begin
      expDone = 1 + WP + H; expReady = expDone + 1;
    end else begin
      expDone = RD; expReady = RD + TZ;
    end
    while (!reqReady) @(negedge clk);
    fallsBefore = csFalls;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = $urandom();
    check(reqReady == 1'b0, "R7", "ready low after accept", int'(reqReady), 0);
    n = 0;
    while (!reqDone && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == expDone, "R9", "done latency", n, expDone);
    if (m != 2'b00 && !wr)
      check(reqRdata == laneView(shadow[a], m), "R2", "read data", int'(reqRdata),
            int'(laneView(shadow[a], m)));
    r = n;
    @(negedge clk);
    r++;
    check(reqDone == 1'b0, "R9", "done is one cycle", int'(reqDone), 0);
    while (!reqReady && r < 100) begin
      @(negedge clk);
      r++;
    end
    check(r == expReady, "R7", "ready latency", r, expReady);
    if (m == 2'b00)
      check(csFalls == fallsBefore, "R8", "null request strobed chip", csFalls - fallsBefore, 0);
    if (wr) begin
      shadow[a] = merge(shadow[a], d, m);
      check(mem[a] == shadow[a], "R3", "memory word after write", int'(mem[a]), int'(shadow[a]));
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 16'(i * 16'h0101 + 16'h1357);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1 && reqDone == 1'b0, "R1", "handshake in reset", int'({reqReady, reqDone}), 2);
    check({memCsN, memWeN, memOeN, memUbN, memLbN} == 5'b11111, "R1", "strobes in reset",
          int'({memCsN, memWeN, memOeN, memUbN, memLbN}), 5'h1f);
    check(memDoe == 1'b0, "R1", "drive in reset", int'(memDoe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && memCsN == 1'b1 && memDoe == 1'b0, "R1", "after reset", int'(reqReady), 1);
    check(cyc(3) == 1 && RD == cyc(55), "R2", "cycle rounding", cyc(3), 1);

    // Directed cases
    doOp(1'b1, 8'h10, 16'hA55A, 2'b11);      // R4 full write
    doOp(1'b0, 8'h10, 16'h0000, 2'b11);      // R2 full read
    doOp(1'b1, 8'h10, 16'hFF11, 2'b01);      // R3 lower lane only
    doOp(1'b0, 8'h10, 16'h0000, 2'b11);
    doOp(1'b1, 8'h10, 16'h22EE, 2'b10);      // R3 upper lane only
    doOp(1'b0, 8'h10, 16'h0000, 2'b01);      // R3 upper lane reads zero
    doOp(1'b0, 8'h10, 16'h0000, 2'b10);      // R3 lower lane reads zero
    doOp(1'b1, 8'h11, 16'hDEAD, 2'b00);      // R8 null write
    doOp(1'b0, 8'h11, 16'h0000, 2'b11);      // R8 memory unchanged
    doOp(1'b0, 8'h11, 16'h0000, 2'b00);      // R8 null read
    doOp(1'b0, 8'h20, 16'h0000, 2'b11);      // R6 read then write at once
    doOp(1'b1, 8'h21, 16'h1234, 2'b11);
    doOp(1'b1, 8'h22, 16'h5678, 2'b11);      // R5 back-to-back writes
    doOp(1'b1, 8'h23, 16'h9ABC, 2'b11);

    // Random mix on a small address range
    for (int k = 0; k < 80; k++) begin
      doOp(1'($urandom_range(0, 1)), 8'($urandom_range(0, 15)), 16'($urandom()),
           2'($urandom_range(0, 3)));
    end
    for (int k = 0; k < 16; k++) doOp(1'b0, 8'(k), 16'h0000, 2'b11);

    finishRun();
  end

endmodule